// File: doc/BRIEF.md
# Supervisory reset pulse generator

This block turns two condition inputs into the reset lines for a processor. The first is a flag that says the supply is below its threshold. An external comparator drives it, and it arrives already synchronized to the block's clock. The second is an active-low manual reset request taken straight from a switch or a logic output.

Reset stays asserted for as long as either condition holds. Once both conditions have cleared, reset stays asserted for a further fixed stretch of `STRETCH_TICKS` clock cycles. The same stretch is applied when the power-on reset releases.

The stretch also serves as the debounce filter for a bouncing switch. While reset is asserted, any low sample on the manual input reloads the stretch. A manual request that arrives while reset is released is accepted only after it has stayed low for `MIN_PULSE` synchronized cycles. Two outputs are provided: an active-low reset and an active-high copy. Each comes from its own flop.

Top module: `sup_reset_gen`

## Requirements
- R1: While `por_n` is low, `rst_n_o` is 0 and `rst_o` is 1. Both change immediately, without waiting for a clock edge.
- R2: When `supply_low` is 1 at a rising clock edge, `rst_n_o` is 0 after that edge.
- R3: Suppose `supply_low` is sampled 1 at one edge and 0 at every later edge, and the manual input is idle. Then `rst_n_o` rises exactly `STRETCH_TICKS` edges after the first edge that samples 0. It stays 0 until then.
- R4: `mr_n` passes through `SYNC_STAGES` flops. When reset is released, driving `mr_n` low and holding it asserts reset on the edge `SYNC_STAGES + MIN_PULSE` edges after the low level is first set up.
- R5: When reset is released, a low pulse on `mr_n` shorter than `MIN_PULSE` cycles is ignored, and `rst_n_o` stays 1.
- R6: After an accepted manual request, `rst_n_o` rises `STRETCH_TICKS + SYNC_STAGES` edges after `mr_n` returns high.
- R7: While reset is asserted, a single low cycle on `mr_n` reloads the stretch. `rst_n_o` then rises `STRETCH_TICKS + SYNC_STAGES + 1` edges after that cycle.
- R8: `rst_o` is at all times the inverse of `rst_n_o`.
- R9: After `por_n` releases with both inputs idle, `rst_n_o` rises after exactly `STRETCH_TICKS` edges.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Free-running clock |
| por_n | input | 1 | Asynchronous power-on reset, active low |
| supply_low | input | 1 | Synchronized flag, 1 while the supply is below threshold |
| mr_n | input | 1 | Raw manual reset request, active low |
| rst_n_o | output | 1 | Reset output, active low |
| rst_o | output | 1 | Reset output, active high |

## Verification
The assertions assume that `supply_low` is already synchronous to `clk`. They also assume that `por_n` is low at time zero, so every counter in the checker starts from a known value. The bench changes `supply_low`, `mr_n` and `por_n` only on the falling clock edge, so each input is stable around the sampling edge. Manual pulses are random runs of high and low levels, both shorter and longer than `MIN_PULSE`. This exercises the acceptance filter and the bounce reload. Supply-low episodes are kept sparse so that full stretches complete between them.

// File: rtl/sup_reset_pkg.sv
package sup_reset_pkg;
    // Idle level of the active-low manual request.
    localparam logic MR_RELEASED = 1'b1;

    // Bits needed to hold values 0..maxval.
    function automatic int unsigned cnt_width(input int unsigned maxval);
        return (maxval < 2) ? 1 : $clog2(maxval + 1);
    endfunction
endpackage

// File: rtl/sup_mr_sync.sv
module sup_mr_sync
    import sup_reset_pkg::*;
#(
    parameter int unsigned STAGES = 2
) (
    input  logic clk,
    input  logic por_n,
    input  logic mr_raw_n,
    output logic mr_sync_n
);
    typedef struct packed {
        logic [STAGES-1:0] chain;
    } sync_t;

    sync_t st_d, st_q;

    // Shift the raw request one flop further along the chain each cycle.
    always_comb begin
        st_d = st_q;
        st_d.chain[0] = mr_raw_n;
        for (int i = 1; i < STAGES; i++) begin
            st_d.chain[i] = st_q.chain[i-1];
        end
    end

    always_ff @(posedge clk or negedge por_n) begin
        if (!por_n) st_q <= {STAGES{MR_RELEASED}};
        else        st_q <= st_d;
    end

    assign mr_sync_n = st_q.chain[STAGES-1];
endmodule

// File: rtl/sup_mr_filter.sv
module sup_mr_filter
    import sup_reset_pkg::*;
#(
    parameter int unsigned MIN_PULSE = 4
) (
    input  logic clk,
    input  logic por_n,
    input  logic mr_sync_n,
    output logic mr_accept
);
    localparam int unsigned LW = cnt_width(MIN_PULSE);
    localparam logic [LW-1:0] LOW_LIMIT = LW'(MIN_PULSE - 1);

    typedef struct packed {
        logic [LW-1:0] low_run;
    } filt_t;

    filt_t st_d, st_q;

    // Count consecutive low samples, saturating at the acceptance limit.
    always_comb begin
        st_d = st_q;
        if (mr_sync_n)
            st_d.low_run = '0;
        else if (st_q.low_run != LOW_LIMIT)
            st_d.low_run = st_q.low_run + 1'b1;
    end

    always_ff @(posedge clk or negedge por_n) begin
        if (!por_n) st_q <= '0;
        else        st_q <= st_d;
    end

    // Accept on the MIN_PULSE-th consecutive low sample.
    assign mr_accept = !mr_sync_n && (st_q.low_run == LOW_LIMIT);
endmodule

// File: rtl/sup_stretch.sv
module sup_stretch
    import sup_reset_pkg::*;
#(
    parameter int unsigned STRETCH_TICKS = 1000
) (
    input  logic clk,
    input  logic por_n,
    input  logic hold,
    output logic rst_n_o,
    output logic rst_o,
    output logic active
);
    localparam int unsigned CW = cnt_width(STRETCH_TICKS);
    localparam logic [CW-1:0] FULL = CW'(STRETCH_TICKS);

    typedef struct packed {
        logic [CW-1:0] cnt;
        logic          rst_n;
        logic          rst;
    } str_t;

    str_t st_d, st_q;
    logic [CW-1:0] cnt_nxt;

    // Reload while a request is present, otherwise count down to zero.
    always_comb begin
        st_d = st_q;
        if (hold)
            cnt_nxt = FULL;
        else if (st_q.cnt != '0)
            cnt_nxt = st_q.cnt - 1'b1;
        else
            cnt_nxt = '0;
        st_d.cnt   = cnt_nxt;
        st_d.rst_n = (cnt_nxt == '0);
        st_d.rst   = (cnt_nxt != '0);
    end

    always_ff @(posedge clk or negedge por_n) begin
        if (!por_n) begin
            st_q.cnt   <= FULL;
            st_q.rst_n <= 1'b0;
            st_q.rst   <= 1'b1;
        end else begin
            st_q <= st_d;
        end
    end

    assign rst_n_o = st_q.rst_n;
    assign rst_o   = st_q.rst;
    assign active  = st_q.rst;
endmodule

// File: rtl/sup_reset_gen.sv
module sup_reset_gen
    import sup_reset_pkg::*;
#(
    parameter int unsigned STRETCH_TICKS = 1000,
    parameter int unsigned MIN_PULSE     = 4,
    parameter int unsigned SYNC_STAGES   = 2
) (
    input  logic clk,
    input  logic por_n,
    input  logic supply_low,
    input  logic mr_n,
    output logic rst_n_o,
    output logic rst_o
);
    logic mr_sync_n;
    logic mr_accept;
    logic active;
    logic hold_d;

    sup_mr_sync #(.STAGES(SYNC_STAGES)) u_sync (
        .clk       (clk),
        .por_n     (por_n),
        .mr_raw_n  (mr_n),
        .mr_sync_n (mr_sync_n)
    );

    sup_mr_filter #(.MIN_PULSE(MIN_PULSE)) u_filter (
        .clk       (clk),
        .por_n     (por_n),
        .mr_sync_n (mr_sync_n),
        .mr_accept (mr_accept)
    );

    // A low sample during an active reset restarts the stretch (debounce).
    always_comb begin
        hold_d = supply_low | mr_accept | (!mr_sync_n & active);
    end

    sup_stretch #(.STRETCH_TICKS(STRETCH_TICKS)) u_stretch (
        .clk     (clk),
        .por_n   (por_n),
        .hold    (hold_d),
        .rst_n_o (rst_n_o),
        .rst_o   (rst_o),
        .active  (active)
    );
endmodule

// File: rtl/sup_reset_chk.sv
module sup_reset_chk
    import sup_reset_pkg::*;
#(
    parameter int unsigned STRETCH_TICKS = 1000
) (
    input logic clk,
    input logic por_n,
    input logic supply_low,
    input logic rst_n_o,
    input logic rst_o
);
    localparam int unsigned CW = cnt_width(STRETCH_TICKS);
    localparam logic [CW-1:0] FULL = CW'(STRETCH_TICKS);

    logic [CW-1:0] since_q;
    logic [CW-1:0] quiet_q;

    // Edges since power-on release, and edges since supply_low was last seen high.
    always_ff @(posedge clk or negedge por_n) begin
        if (!por_n) begin
            since_q <= '0;
            quiet_q <= '0;
        end else begin
            if (since_q != FULL) since_q <= since_q + 1'b1;
            if (supply_low)          quiet_q <= '0;
            else if (quiet_q != FULL) quiet_q <= quiet_q + 1'b1;
        end
    end

    // R8
    out_complement_chk: assert property (@(posedge clk) disable iff (!por_n)
        rst_o == !rst_n_o);

    // R2
    supply_hold_chk: assert property (@(posedge clk) disable iff (!por_n)
        supply_low |=> !rst_n_o);

    // R9
    por_window_chk: assert property (@(posedge clk) disable iff (!por_n)
        (since_q < FULL) |-> !rst_n_o);

    // R3
    release_gap_chk: assert property (@(posedge clk) disable iff (!por_n)
        $rose(rst_n_o) |-> (quiet_q >= FULL));
endmodule

bind sup_reset_gen sup_reset_chk #(.STRETCH_TICKS(STRETCH_TICKS)) u_chk (
    .clk        (clk),
    .por_n      (por_n),
    .supply_low (supply_low),
    .rst_n_o    (rst_n_o),
    .rst_o      (rst_o)
);

// File: tb/tb_sup_reset_gen.sv
`timescale 1ns/1ps
module tb_sup_reset_gen;
    localparam int N    = 40;
    localparam int MINP = 3;

    logic clk = 1'b0;
    logic por_i = 1'b0;
    logic sup_i = 1'b0;
    logic mrn_i = 1'b1;
    logic rst_n_o, rst_o;
    int   nchecks = 0;
    int   nfail   = 0;
    bit   done    = 0;

    // Reference state, built from the requirements.
    logic [1:0] m_s;
    int         m_low;
    int         m_cnt;

    always #4 clk = ~clk;

    sup_reset_gen #(.STRETCH_TICKS(N), .MIN_PULSE(MINP), .SYNC_STAGES(2)) dut (
        .clk(clk), .por_n(por_i), .supply_low(sup_i), .mr_n(mrn_i),
        .rst_n_o(rst_n_o), .rst_o(rst_o)
    );

    task automatic chk(input bit ok, input string tag, input int act, input int exp);
        nchecks++;
        if (!ok) begin
            nfail++;
            $display("FAIL %s act=%0d exp=%0d", tag, act, exp);
        end
    endtask

    function automatic void model_reset();
        m_s = 2'b11; m_low = 0; m_cnt = N;
    endfunction

    function automatic void model_step();
        logic mr_s;
        bit   hold;
        if (!por_i) begin
            model_reset();
            return;
        end
        mr_s = m_s[1];
        hold = sup_i || (!mr_s && (m_low == MINP-1 || m_cnt != 0));
        m_low = mr_s ? 0 : ((m_low == MINP-1) ? m_low : m_low + 1);
        m_cnt = hold ? N : ((m_cnt != 0) ? m_cnt - 1 : 0);
        m_s = {m_s[0], mrn_i};
    endfunction

    task automatic step(input string tag);
        @(posedge clk);
        model_step();
        @(negedge clk);
        chk(rst_n_o == (m_cnt == 0), tag, int'(rst_n_o), int'(m_cnt == 0));
        chk(rst_o == !rst_n_o, "R8", int'(rst_o), int'(!rst_n_o));
    endtask

    task automatic count_release(input string tag, input int exp);
        int n = 0;
        while (!rst_n_o && n < exp + 8) begin
            step(tag);
            n++;
        end
        chk(n == exp, tag, n, exp);
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        if (!done) begin
            nfail++;
            $display("FAIL watchdog act=0 exp=1");
            $display("TB_RESULT checks=%0d failures=%0d", nchecks, nfail);
            $finish;
        end
    end

    initial begin
        void'($urandom(32'd7391));
        model_reset();
        // R1: power-on reset state
        repeat (3) @(negedge clk);
        chk(rst_n_o == 1'b0, "R1", int'(rst_n_o), 0);
        chk(rst_o == 1'b1, "R1", int'(rst_o), 1);
        por_i = 1'b1;
        // R9: idle release after power-on
        count_release("R9", N);
        repeat (3) step("R9");

        // R2 / R3: supply-low episode
        sup_i = 1'b1;
        for (int i = 0; i < 10; i++) begin
            step("R2");
            chk(rst_n_o == 1'b0, "R2", int'(rst_n_o), 0);
        end
        sup_i = 1'b0;
        count_release("R3", N);
        repeat (3) step("R3");

        // R5: short manual pulse while released
        mrn_i = 1'b0;
        repeat (MINP-1) step("R5");
        mrn_i = 1'b1;
        for (int i = 0; i < 10; i++) begin
            step("R5");
            chk(rst_n_o == 1'b1, "R5", int'(rst_n_o), 1);
        end

        // R4: accepted manual pulse, exact assertion edge
        mrn_i = 1'b0;
        repeat (MINP+1) step("R4");
        chk(rst_n_o == 1'b1, "R4", int'(rst_n_o), 1);
        step("R4");
        chk(rst_n_o == 1'b0, "R4", int'(rst_n_o), 0);
        repeat (5) step("R4");
        // R6: stretch after manual release
        mrn_i = 1'b1;
        count_release("R6", N + 2);
        repeat (3) step("R6");

        // R7: bounce during stretch reloads it
        sup_i = 1'b1;
        step("R7");
        sup_i = 1'b0;
        repeat (10) step("R7");
        mrn_i = 1'b0;
        step("R7");
        mrn_i = 1'b1;
        count_release("R7", N + 2);

        // R1: power-on reset in the middle of a stretch
        sup_i = 1'b1;
        repeat (3) step("R1");
        sup_i = 1'b0;
        repeat (5) step("R1");
        por_i = 1'b0;
        #1;
        chk(rst_n_o == 1'b0 && rst_o == 1'b1, "R1", int'(rst_n_o), 0);
        step("R1");
        por_i = 1'b1;
        count_release("R9", N);

        // Random mix of all inputs, checked cycle by cycle against the model.
        for (int i = 0; i < 6000; i++) begin
            int r = int'($urandom_range(0, 999));
            if (r < 4)        sup_i = 1'b1;
            else if (r < 60)  sup_i = 1'b0;
            if ($urandom_range(0, 3) == 0) mrn_i = ($urandom_range(0, 2) != 0);
            if (r == 999)     por_i = 1'b0;
            else              por_i = 1'b1;
            step("R8_rand");
        end

        done = 1;
        $display("TB_RESULT checks=%0d failures=%0d", nchecks, nfail);
        $finish;
    end
endmodule